// File: doc/BRIEF.md
# Two-Frame Elastic Slip Buffer

This block decouples an E1 bit stream recovered on a line clock from a system backplane that runs on its own clock, which may differ from the line clock in both phase and frequency. Serial bits enter on the line clock. A frame strobe marks the first bit of every 256-bit frame, and each frame holds 32 eight-bit timeslots. The block stores up to two whole frames and sends them out serially on the system clock. A sync pulse on the system side fixes where the read frame begins.

The writer's position crosses into the system domain as a Gray-coded count of quarter-frames. At every read frame boundary the reader measures how far ahead the writer is. If the writer is close behind, the reader replays the frame it has just sent. If the writer is too far ahead, the reader skips one frame. A slip therefore always moves by a whole frame, so frame alignment survives. Two sticky flags record which kind of slip took place, and they stay set until the system clears them. With the buffer disabled, the output carries the line data, registered once on the line clock.

Top module: `e1SlipBuffer`

## Requirements
- R1: While reset is asserted, `dataOut`, `slipRepeat` and `slipDelete` are all 0.
- R2: Each frame leaves the buffer bit for bit as it was written. Timeslot 0 comes first, and within each timeslot the most significant bit comes first.
- R3: With `enable` high, a `sysSync` pulse sampled on a `sysClk` edge restarts the read frame. Bit 0 of a stored frame appears on `dataOut` after the second rising `sysClk` edge that follows.
- R4: When the line and system clocks run at the same rate, frames come out in the order they were written and neither slip flag is set.
- R5: When the writer runs slower than the reader, the reader sends the previous frame once more at a frame boundary and sets `slipRepeat`.
- R6: When the writer runs faster than the reader, the reader skips exactly one whole frame at a frame boundary and sets `slipDelete`.
- R7: A slip happens only at a read frame boundary. Between two consecutive output frames the frame sequence number advances by 0, 1 or 2, and no output frame mixes data from two written frames.
- R8: Both slip flags stay set until `slipClr` is pulsed. One `sysClk` cycle after that pulse they read 0, unless a new slip occurs in the same cycle.
- R9: With `enable` low, `dataOut` equals the `lineData` value sampled at the most recent rising edge of `lineClk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lineClk | input | 1 | Recovered line clock, one bit per cycle |
| lineData | input | 1 | Serial line data |
| lineFrameStart | input | 1 | High with bit 0 of every written frame |
| sysClk | input | 1 | System backplane clock |
| sysSync | input | 1 | System frame sync pulse; restarts the read frame |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| enable | input | 1 | 1 = buffered output on sysClk, 0 = bypass on lineClk |
| slipClr | input | 1 | Clears both sticky slip flags (sysClk domain) |
| dataOut | output | 1 | Serial output data |
| slipRepeat | output | 1 | Sticky: a frame was repeated |
| slipDelete | output | 1 | Sticky: a frame was dropped |

## Verification
Each written frame carries its sequence number in timeslot 0 and a pattern derived from that number in the other timeslots. A fault in a pointer or in the memory therefore appears at the output within one frame, either as a bit mismatch or as a step between frame numbers that is not allowed. A wrong slip decision or a wrong flag update is visible eight cycles after the frame boundary, when the sequence number has been read out and compared with both flags. Faults in the bypass path appear on the very next line clock.

// File: rtl/esbPkg.sv
`timescale 1ns/1ps
package esbPkg;
  localparam int SlotBits  = 8;
  localparam int Slots     = 32;
  localparam int FrameBits = SlotBits * Slots;
  localparam int BitW      = $clog2(FrameBits);
  localparam int Frames    = 2;
  localparam int SlotSelW  = $clog2(Frames);
  localparam int LapW      = SlotSelW + 1;
  localparam int SubW      = 2;
  localparam int SubDiv    = 1 << SubW;
  localparam int PtrW      = LapW + SubW;
  localparam int AddrW     = SlotSelW + BitW;
  localparam int MemBits   = Frames * FrameBits;

  typedef struct packed {
    logic             we;
    logic [AddrW-1:0] wAddr;
  } wrStrobe_t;

  typedef struct packed {
    logic [AddrW-1:0] rAddr;
  } rdStrobe_t;

  typedef enum logic [1:0] {SLIP_NONE, SLIP_REPEAT, SLIP_DELETE} slipKind_t;

  function automatic logic [PtrW-1:0] binToGray(input logic [PtrW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PtrW-1:0] grayToBin(input logic [PtrW-1:0] g);
    logic [PtrW-1:0] b;
    b[PtrW-1] = g[PtrW-1];
    for (int i = PtrW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/esbCtrl.sv
`timescale 1ns/1ps
module esbCtrl
  import esbPkg::*;
(
  input  logic      lineClk,
  input  logic      sysClk,
  input  logic      rstN,
  input  logic      lineFrameStart,
  input  logic      sysSync,
  input  logic      enable,
  input  logic      slipClr,
  output wrStrobe_t wrStb,
  output rdStrobe_t rdStb,
  output logic      slipRepeat,
  output logic      slipDelete
);
  localparam logic [BitW-1:0] LastBit = BitW'(FrameBits - 1);
  localparam logic [PtrW-1:0] LowQ    = PtrW'(SubDiv / 2);
  localparam logic [PtrW-1:0] HighQ   = PtrW'(SubDiv + SubDiv / 2);
  localparam logic [PtrW-1:0] NegQ    = PtrW'(3 * SubDiv);

  // ---------------- write side (line clock) ----------------
  logic            started;
  logic [LapW-1:0] wrFrame, curFrame, nxtFrame;
  logic [BitW-1:0] wrBit, curBit, nxtBit;
  logic [PtrW-1:0] wrGray;
  logic            wrGo;

  always_comb begin
    wrGo = started | lineFrameStart;
    if (lineFrameStart && started && (wrBit != '0)) begin
      curFrame = wrFrame + 1'b1;
      curBit   = '0;
    end else if (lineFrameStart) begin
      curFrame = wrFrame;
      curBit   = '0;
    end else begin
      curFrame = wrFrame;
      curBit   = wrBit;
    end
    if (curBit == LastBit) begin
      nxtFrame = curFrame + 1'b1;
      nxtBit   = '0;
    end else begin
      nxtFrame = curFrame;
      nxtBit   = curBit + 1'b1;
    end
  end

  assign wrStb.we    = wrGo;
  assign wrStb.wAddr = {curFrame[SlotSelW-1:0], curBit};

  always_ff @(posedge lineClk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      wrFrame <= '0;
      wrBit   <= '0;
      wrGray  <= '0;
    end else if (wrGo) begin
      started <= 1'b1;
      wrFrame <= nxtFrame;
      wrBit   <= nxtBit;
      wrGray  <= binToGray({nxtFrame, nxtBit[BitW-1 -: SubW]});
    end
  end

  // ---------------- crossing into system clock ----------------
  logic [PtrW-1:0] grayMeta, graySync, wrQuarter;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      grayMeta <= '0;
      graySync <= '0;
    end else begin
      grayMeta <= wrGray;
      graySync <= grayMeta;
    end
  end

  assign wrQuarter = grayToBin(graySync);

  // ---------------- read side (system clock) ----------------
  logic [LapW-1:0] rdFrame, nextFrame, rdTarget;
  logic [BitW-1:0] rdBit;
  logic [PtrW-1:0] lead;
  logic            syncHit, boundary;
  slipKind_t       slipKind;

  always_comb begin
    syncHit   = sysSync & enable;
    boundary  = syncHit | (rdBit == LastBit);
    nextFrame = rdFrame + 1'b1;
    lead      = wrQuarter - {nextFrame, {SubW{1'b0}}};
    if (lead < LowQ || lead >= NegQ)  slipKind = SLIP_REPEAT;
    else if (lead > HighQ)            slipKind = SLIP_DELETE;
    else                              slipKind = SLIP_NONE;
    unique case (slipKind)
      SLIP_REPEAT: rdTarget = rdFrame;
      SLIP_DELETE: rdTarget = nextFrame + 1'b1;
      default:     rdTarget = nextFrame;
    endcase
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      rdFrame    <= '1;
      rdBit      <= '0;
      slipRepeat <= 1'b0;
      slipDelete <= 1'b0;
    end else begin
      if (boundary) begin
        rdFrame <= rdTarget;
        rdBit   <= '0;
      end else begin
        rdBit   <= rdBit + 1'b1;
      end
      if (boundary && slipKind == SLIP_REPEAT) slipRepeat <= 1'b1;
      else if (slipClr)                        slipRepeat <= 1'b0;
      if (boundary && slipKind == SLIP_DELETE) slipDelete <= 1'b1;
      else if (slipClr)                        slipDelete <= 1'b0;
    end
  end

  assign rdStb.rAddr = {rdFrame[SlotSelW-1:0], rdBit};

  // ---------------- assertions ----------------
  AST_GRAY_ONE_STEP: assert property (@(posedge lineClk) disable iff (!rstN)
    started |=> ($countones(wrGray ^ $past(wrGray)) <= 1)); // R7

  AST_WRITE_WRAP: assert property (@(posedge lineClk) disable iff (!rstN)
    (started && wrBit == LastBit && !lineFrameStart) |=> (wrBit == '0)); // R2

  AST_SLIP_AT_BOUNDARY: assert property (@(posedge sysClk) disable iff (!rstN)
    !$stable(rdFrame) |-> (rdBit == '0)); // R7

  AST_FRAME_STEP: assert property (@(posedge sysClk) disable iff (!rstN)
    !$stable(rdFrame) |-> ((rdFrame == LapW'($past(rdFrame) + 1'b1)) ||
                           (rdFrame == LapW'($past(rdFrame) + 2'd2)))); // R6

  AST_SYNC_ALIGN: assert property (@(posedge sysClk) disable iff (!rstN)
    (sysSync && enable) |=> (rdBit == '0)); // R3

  AST_REPEAT_STICKY: assert property (@(posedge sysClk) disable iff (!rstN)
    (slipRepeat && !slipClr) |=> slipRepeat); // R8

  AST_DELETE_STICKY: assert property (@(posedge sysClk) disable iff (!rstN)
    (slipDelete && !slipClr) |=> slipDelete); // R8
endmodule

// File: rtl/esbData.sv
`timescale 1ns/1ps
module esbData
  import esbPkg::*;
(
  input  logic      lineClk,
  input  logic      sysClk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      lineData,
  input  wrStrobe_t wrStb,
  input  rdStrobe_t rdStb,
  output logic      dataOut
);
  logic [MemBits-1:0] store;
  logic               lineReg;
  logic               rdReg;

  always_ff @(posedge lineClk) begin
    if (wrStb.we) store[wrStb.wAddr] <= lineData;
  end

  always_ff @(posedge lineClk or negedge rstN) begin
    if (!rstN) lineReg <= 1'b0;
    else       lineReg <= lineData;
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) rdReg <= 1'b0;
    else       rdReg <= store[rdStb.rAddr];
  end

  assign dataOut = enable ? rdReg : lineReg;

  AST_BYPASS_FOLLOWS_LINE: assert property (@(posedge lineClk) disable iff (!rstN)
    !enable |=> (enable || dataOut == $past(lineData))); // R9
endmodule

// File: rtl/e1SlipBuffer.sv
`timescale 1ns/1ps
module e1SlipBuffer
  import esbPkg::*;
(
  input  logic lineClk,
  input  logic lineData,
  input  logic lineFrameStart,
  input  logic sysClk,
  input  logic sysSync,
  input  logic rstN,
  input  logic enable,
  input  logic slipClr,
  output logic dataOut,
  output logic slipRepeat,
  output logic slipDelete
);
  wrStrobe_t wrStb;
  rdStrobe_t rdStb;

  esbCtrl uCtrl (
    .lineClk(lineClk), .sysClk(sysClk), .rstN(rstN),
    .lineFrameStart(lineFrameStart), .sysSync(sysSync),
    .enable(enable), .slipClr(slipClr),
    .wrStb(wrStb), .rdStb(rdStb),
    .slipRepeat(slipRepeat), .slipDelete(slipDelete)
  );

  esbData uData (
    .lineClk(lineClk), .sysClk(sysClk), .rstN(rstN),
    .enable(enable), .lineData(lineData),
    .wrStb(wrStb), .rdStb(rdStb), .dataOut(dataOut)
  );
endmodule

// File: tb/e1SlipBuffer_test.sv
`timescale 1ns/1ps
module e1SlipBuffer_test;
  logic lineClk = 0, sysClk = 0, rstN = 0;
  logic lineData = 0, lineFrameStart = 0, sysSync = 0, enable = 1, slipClr = 0;
  logic dataOut, slipRepeat, slipDelete;
  real  linePeriod = 5.0;

  int checks = 0, fails = 0;
  int repSeen = 0, delSeen = 0, normSeen = 0;

  e1SlipBuffer uut (
    .lineClk(lineClk), .lineData(lineData), .lineFrameStart(lineFrameStart),
    .sysClk(sysClk), .sysSync(sysSync), .rstN(rstN), .enable(enable),
    .slipClr(slipClr), .dataOut(dataOut), .slipRepeat(slipRepeat),
    .slipDelete(slipDelete)
  );

  always #2.5 sysClk = ~sysClk;
  initial begin
    #1.1;
    forever #(linePeriod / 2.0) lineClk = ~lineClk;
  end

  // reference pattern: timeslot 0 carries the frame number, MSB first
  function automatic logic patBit(input int id, input int k);
    logic [7:0] v;
    int slot;
    slot = k / 8;
    v = (slot == 0) ? 8'(id) : 8'(id * 7 + slot * 29 + 5);
    return v[7 - (k % 8)];
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- line-side writer and bypass checker ----------------
  logic writerOn = 0, bypassChk = 0;
  int   wId = 0, wBit = 0;

  always @(negedge lineClk) begin
    if (bypassChk) check(dataOut === lineData, "R9", "bypass data", dataOut, lineData);
    if (writerOn) begin
      lineData       = patBit(wId, wBit);
      lineFrameStart = (wBit == 0);
      wBit++;
      if (wBit == 256) begin
        wBit = 0;
        wId  = (wId + 1) % 256;
      end
    end
  end

  // ---------------- system-side reference monitor ----------------
  logic       monOn = 0, reqSync = 0;
  int         obsBit = -1000, frameNo = 0, prevId = 0, curId = 0;
  logic [7:0] curByte = 0;
  logic       expRep = 0, expDel = 0;

  always @(negedge sysClk) begin
    sysSync = 0;
    slipClr = 0;
    if (monOn) begin
      obsBit++;
      if (obsBit == 256) obsBit = 0;
      if (obsBit >= 0) begin
        if (obsBit < 8) curByte = {curByte[6:0], dataOut};
        if (obsBit == 7) begin
          curId = int'(curByte);
          frameNo++;
          if (frameNo >= 5) begin
            case (8'(curId - prevId))
              8'd1: begin expRep = 0; expDel = 0; normSeen++;
                      check(slipRepeat === 0 && slipDelete === 0, "R4", "flags on normal step",
                            {slipRepeat, slipDelete}, 0); end
              8'd0: begin expRep = 1; expDel = 0; repSeen++;
                      check(slipRepeat === 1 && slipDelete === 0, "R5", "flags on repeat",
                            {slipRepeat, slipDelete}, 2); end
              8'd2: begin expRep = 0; expDel = 1; delSeen++;
                      check(slipRepeat === 0 && slipDelete === 1, "R6", "flags on delete",
                            {slipRepeat, slipDelete}, 1); end
              default: check(0, "R7", "frame number step", 8'(curId - prevId), 1);
            endcase
          end
          prevId = curId;
        end else if (obsBit >= 8 && frameNo >= 4) begin
          check(dataOut === patBit(curId, obsBit), (frameNo == 4) ? "R3" : "R2",
                "frame bit", dataOut, patBit(curId, obsBit));
        end
        if (obsBit == 50 && frameNo >= 5)
          check(slipRepeat === expRep && slipDelete === expDel, "R8", "flags held",
                {slipRepeat, slipDelete}, {expRep, expDel});
        if (obsBit == 100) slipClr = 1;
        if (obsBit == 120 && frameNo >= 5)
          check(slipRepeat === 0 && slipDelete === 0, "R8", "flags after clear",
                {slipRepeat, slipDelete}, 0);
      end
    end
    if (reqSync) begin
      sysSync = 1;
      obsBit  = -2;
      frameNo = 0;
      reqSync = 0;
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic waitFrames(input int n);
    repeat (n * 256) @(posedge sysClk);
  endtask

  initial begin
    repeat (150000) @(posedge sysClk);
    check(0, "R1", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge sysClk);
    @(negedge sysClk);
    check(dataOut === 0, "R1", "dataOut in reset", dataOut, 0);
    check(slipRepeat === 0, "R1", "slipRepeat in reset", slipRepeat, 0);
    check(slipDelete === 0, "R1", "slipDelete in reset", slipDelete, 0);
    rstN = 1;
    writerOn = 1;
    waitFrames(3);
    @(posedge sysClk);
    monOn = 1;
    reqSync = 1;

    // equal rates
    waitFrames(20);
    check(repSeen == 0 && delSeen == 0, "R4", "slips at equal rate", repSeen + delSeen, 0);
    check(normSeen >= 10, "R4", "normal frames at equal rate", normSeen, 10);
    repSeen = 0; delSeen = 0; normSeen = 0;

    // writer faster
    linePeriod = 4.5;
    waitFrames(40);
    check(delSeen >= 1, "R6", "deletes with fast writer", delSeen, 1);
    check(repSeen == 0, "R6", "repeats with fast writer", repSeen, 0);
    repSeen = 0; delSeen = 0; normSeen = 0;

    // writer slower
    linePeriod = 5.5;
    waitFrames(40);
    check(repSeen >= 1, "R5", "repeats with slow writer", repSeen, 1);
    check(delSeen == 0, "R5", "deletes with slow writer", delSeen, 0);
    repSeen = 0; delSeen = 0; normSeen = 0;

    // mid-frame resync
    linePeriod = 5.0;
    repeat (77) @(posedge sysClk);
    reqSync = 1;
    waitFrames(12);
    check(normSeen >= 5, "R3", "frames after resync", normSeen, 5);

    // bypass
    monOn = 0;
    @(posedge sysClk);
    enable = 0;
    @(negedge lineClk);
    bypassChk = 1;
    repeat (300) @(negedge lineClk);
    bypassChk = 0;

    summary();
    $finish;
  end
endmodule